// File: doc/BRIEF.md
# Crosspoint Live Routing Stage

This block is the routing core of a 16-input, 8-output digital crosspoint. It holds one live register per output: a 4-bit input select and an off flag. Every output either forwards the selected input bit with its enable high, or is disabled with its enable low and its data held at 0. A disabled output does not drive, so two such blocks can share output wires as long as only one of them enables each wire.

A serial front end, which is not part of this block, supplies a staged bank of select and off values and a level flag that marks the bank as fresh. The block copies the staged bank into the live registers on the rising edge of an asynchronous configure pin, but only while the fresh flag is set. On each copy it returns a one-cycle clear pulse so the front end can drop the flag. Two asynchronous level pins override routing. Shutdown disables every output and clears every live register to input 0 and off. Broadcast enables every output and routes input 0 to each of them. Shutdown wins over broadcast.

A three-state controller selects the output view: `XM_ROUTE` shows the live registers, `XM_BCAST` shows input 0 on every output, and `XM_SHUT` shows all outputs disabled. The controller enters `XM_SHUT` from any state while the synchronised shutdown level is high. Otherwise it enters `XM_BCAST` while the broadcast level is high, and `XM_ROUTE` when neither is high. Each pin passes through a two-flop synchroniser. A pin change therefore shows at the outputs after three clock edges, and a configure edge loads the live registers at the third edge.

Top module: `xp_live_route`

## Requirements
- R1: After reset, all enables in `out_en` are 0 and `out_sig` is 0. The live registers hold input 0 with every output off.
- R2: In routing mode, output k forwards `in_sig[sel_k]`, where `sel_k` is `stage_sel[4k+3:4k]` as it was at the last transfer. Any number of outputs may select the same input.
- R3: An output whose off bit (`stage_off[k]` = 1 at the last transfer) is set has `out_en[k]` = 0 and `out_sig[k]` = 0.
- R4: A rising edge on `cfg_pin` while `stage_fresh` is 1 and shutdown is low copies the whole staged bank into the live registers. The new routing is visible by the fourth rising clock edge after the pin rises.
- R5: A configure edge while `stage_fresh` is 0 leaves the live registers unchanged.
- R6: Each transfer raises `fresh_clr` for exactly one clock cycle, and `fresh_clr` never rises without a transfer.
- R7: While `shut_pin` is high, all outputs are disabled and the live registers are forced to input 0 and off. These cleared values remain in place after the pin is released.
- R8: While `bcast_pin` is high and `shut_pin` is low, every `out_en` bit is 1 and every `out_sig` bit equals `in_sig[0]`.
- R9: When `shut_pin` and `bcast_pin` are both high, shutdown takes effect.
- R10: Releasing `bcast_pin` brings back the live routing that was in place before broadcast.
- R11: Changes on `stage_sel` and `stage_off` without a transfer have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sig | input | 16 | Input signals to route |
| stage_sel | input | 32 | Staged input selects, 4 bits per output |
| stage_off | input | 8 | Staged off flags, 1 = disabled |
| stage_fresh | input | 1 | Staged bank holds data not yet transferred |
| cfg_pin | input | 1 | Asynchronous configure; the rising edge transfers |
| shut_pin | input | 1 | Asynchronous shutdown level |
| bcast_pin | input | 1 | Asynchronous broadcast level |
| out_sig | output | 8 | Routed outputs, 0 when disabled |
| out_en | output | 8 | Output enables |
| fresh_clr | output | 1 | One-cycle pulse on each transfer |

## Verification
Routing is tried in three layouts:
- an identity-like layout, where each output takes a distinct input;
- a fan-out layout, where every output takes input 5 and one output is off;
- a reversed layout, where the upper inputs are used.

Each layout is driven with several input words, so a wrong select bit or a swapped output shows as a bit mismatch. A bank staged without the fresh flag, and then a second configure edge after the flag has been cleared, separate a transfer gated on fresh data from one that fires on every edge. Broadcast alone, shutdown with broadcast, and the release of each pin tell priority, register clearing and restoration apart.

// File: rtl/xp_pkg.sv
package xp_pkg;
    typedef enum logic [1:0] {
        XM_ROUTE = 2'd0,
        XM_BCAST = 2'd1,
        XM_SHUT  = 2'd2
    } xp_mode_e;
endpackage

// File: rtl/xp_sync.sv
module xp_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/xp_ctrl.sv
module xp_ctrl
    import xp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_s,
    input  logic     shut_s,
    input  logic     bcast_s,
    input  logic     fresh,
    output xp_mode_e mode,
    output logic     load
);
    xp_mode_e mode_nx;
    logic     cfg_prev;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode     <= XM_ROUTE;
            cfg_prev <= 1'b0;
        end else begin
            mode     <= mode_nx;
            cfg_prev <= cfg_s;
        end
    end

    // next-state: shutdown outranks broadcast from every state
    always_comb begin
        mode_nx = mode;
        unique case (mode)
            XM_ROUTE: if (shut_s) mode_nx = XM_SHUT;
                      else if (bcast_s) mode_nx = XM_BCAST;
            XM_BCAST: if (shut_s) mode_nx = XM_SHUT;
                      else if (!bcast_s) mode_nx = XM_ROUTE;
            XM_SHUT:  if (!shut_s) mode_nx = bcast_s ? XM_BCAST : XM_ROUTE;
            default:  mode_nx = XM_SHUT;
        endcase
    end

    // output process: a transfer is a configure edge with fresh data, blocked in shutdown
    always_comb begin
        load = 1'b0;
        unique case (mode)
            XM_ROUTE, XM_BCAST: load = cfg_s && !cfg_prev && fresh;
            XM_SHUT:            load = 1'b0;
            default:            load = 1'b0;
        endcase
    end
endmodule

// File: rtl/xp_live_bank.sv
module xp_live_bank
    import xp_pkg::*;
#(
    parameter int N_OUT = 8,
    parameter int SEL_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  xp_mode_e               mode,
    input  logic                   load,
    input  logic [N_OUT*SEL_W-1:0] stg_sel,
    input  logic [N_OUT-1:0]       stg_off,
    output logic [N_OUT*SEL_W-1:0] live_sel,
    output logic [N_OUT-1:0]       live_off
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_sel <= '0;
            live_off <= '1;
        end else if (mode == XM_SHUT) begin
            live_sel <= '0;
            live_off <= '1;
        end else if (load) begin
            live_sel <= stg_sel;
            live_off <= stg_off;
        end
    end
endmodule

// File: rtl/xp_route.sv
module xp_route
    import xp_pkg::*;
#(
    parameter int N_IN  = 16,
    parameter int N_OUT = 8,
    parameter int SEL_W = 4
) (
    input  xp_mode_e               mode,
    input  logic [N_IN-1:0]        in_sig,
    input  logic [N_OUT*SEL_W-1:0] live_sel,
    input  logic [N_OUT-1:0]       live_off,
    output logic [N_OUT-1:0]       out_sig,
    output logic [N_OUT-1:0]       out_en
);
    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        logic [SEL_W-1:0] sel;
        logic             en;
        assign sel = live_sel[k*SEL_W +: SEL_W];

        always_comb begin
            unique case (mode)
                XM_ROUTE: en = !live_off[k];
                XM_BCAST: en = 1'b1;
                XM_SHUT:  en = 1'b0;
                default:  en = 1'b0;
            endcase
        end

        assign out_en[k]  = en;
        assign out_sig[k] = en && ((mode == XM_BCAST) ? in_sig[0] : in_sig[sel]);
    end
endmodule

// File: rtl/xp_live_route.sv
module xp_live_route
    import xp_pkg::*;
#(
    parameter int N_IN  = 16,
    parameter int N_OUT = 8,
    localparam int SEL_W = $clog2(N_IN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        in_sig,
    input  logic [N_OUT*SEL_W-1:0] stage_sel,
    input  logic [N_OUT-1:0]       stage_off,
    input  logic                   stage_fresh,
    input  logic                   cfg_pin,
    input  logic                   shut_pin,
    input  logic                   bcast_pin,
    output logic [N_OUT-1:0]       out_sig,
    output logic [N_OUT-1:0]       out_en,
    output logic                   fresh_clr
);
    logic [2:0]             pins_s;
    xp_mode_e               mode_q;
    logic                   load_w;
    logic [N_OUT*SEL_W-1:0] live_sel_w;
    logic [N_OUT-1:0]       live_off_w;

    xp_sync #(.W(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({bcast_pin, shut_pin, cfg_pin}),
        .q    (pins_s)
    );

    xp_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_s  (pins_s[0]),
        .shut_s (pins_s[1]),
        .bcast_s(pins_s[2]),
        .fresh  (stage_fresh),
        .mode   (mode_q),
        .load   (load_w)
    );

    xp_live_bank #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_q),
        .load    (load_w),
        .stg_sel (stage_sel),
        .stg_off (stage_off),
        .live_sel(live_sel_w),
        .live_off(live_off_w)
    );

    xp_route #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_route (
        .mode    (mode_q),
        .in_sig  (in_sig),
        .live_sel(live_sel_w),
        .live_off(live_off_w),
        .out_sig (out_sig),
        .out_en  (out_en)
    );

    assign fresh_clr = load_w;
endmodule

// File: rtl/xp_live_route_chk.sv
module xp_live_route_chk
    import xp_pkg::*;
#(
    parameter int N_IN  = 16,
    parameter int N_OUT = 8,
    parameter int SEL_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input xp_mode_e               mode,
    input logic                   fresh_clr,
    input logic                   stage_fresh,
    input logic [N_IN-1:0]        in_sig,
    input logic [N_OUT-1:0]       out_sig,
    input logic [N_OUT-1:0]       out_en,
    input logic [N_OUT*SEL_W-1:0] live_sel,
    input logic [N_OUT-1:0]       live_off
);
    p_dis_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sig & ~out_en) == '0);

    p_clr_needs_fresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fresh_clr |-> stage_fresh);

    p_hold_stale_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fresh_clr && mode != XM_SHUT) |=> ($stable(live_sel) && $stable(live_off)));

    p_clr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fresh_clr |=> !fresh_clr);

    p_shut_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XM_SHUT) |-> (out_en == '0));

    p_shut_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XM_SHUT) |=> (live_sel == '0 && live_off == '1));

    p_bcast_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XM_BCAST) |-> (out_en == '1 && out_sig == {N_OUT{in_sig[0]}}));
endmodule

bind xp_live_route xp_live_route_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_q),
    .fresh_clr  (fresh_clr),
    .stage_fresh(stage_fresh),
    .in_sig     (in_sig),
    .out_sig    (out_sig),
    .out_en     (out_en),
    .live_sel   (live_sel_w),
    .live_off   (live_off_w)
);

// File: tb/xp_live_route_test.sv
module xp_live_route_test;
    typedef struct {
        logic [7:0] en;
        logic [7:0] sig;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_sig = '0;
    logic [31:0] stage_sel = '0;
    logic [7:0]  stage_off = '1;
    logic        stage_fresh;
    logic        set_fresh = 1'b0;
    logic        cfg_pin = 1'b0;
    logic        shut_pin = 1'b0;
    logic        bcast_pin = 1'b0;
    logic [7:0]  out_sig, out_en;
    logic        fresh_clr;

    int checks = 0;
    int errors = 0;
    int clr_cnt = 0;
    int wd = 0;
    item_t sbq[$];

    // bench model of the live state, per the requirements
    logic [3:0] m_sel [8];
    logic [7:0] m_off = '1;
    int         m_mode = 0;   // 0 route, 1 broadcast, 2 shutdown

    always #5 clk = ~clk;

    xp_live_route uut (
        .clk(clk), .rst_n(rst_n), .in_sig(in_sig), .stage_sel(stage_sel),
        .stage_off(stage_off), .stage_fresh(stage_fresh), .cfg_pin(cfg_pin),
        .shut_pin(shut_pin), .bcast_pin(bcast_pin), .out_sig(out_sig),
        .out_en(out_en), .fresh_clr(fresh_clr)
    );

    // stand-in for the serial front end's fresh flag
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_fresh <= 1'b0;
        else if (set_fresh) stage_fresh <= 1'b1;
        else if (fresh_clr) stage_fresh <= 1'b0;
    end

    always @(posedge clk) if (rst_n && fresh_clr) clr_cnt++;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items and compares away from the active edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            check(out_en == it.en, {it.tag, " en"}, {24'h0, out_en}, {24'h0, it.en});
            check(out_sig == it.sig, {it.tag, " sig"}, {24'h0, out_sig}, {24'h0, it.sig});
        end
    end

    // driver side: computes and queues the expected outputs
    task automatic expect_now(input string tag);
        item_t it;
        repeat (4) @(posedge clk);
        #1;
        for (int k = 0; k < 8; k++) begin
            case (m_mode)
                2: begin it.en[k] = 1'b0; it.sig[k] = 1'b0; end
                1: begin it.en[k] = 1'b1; it.sig[k] = in_sig[0]; end
                default: begin
                    it.en[k]  = !m_off[k];
                    it.sig[k] = !m_off[k] && in_sig[m_sel[k]];
                end
            endcase
        end
        it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic stage(input logic [31:0] sels, input logic [7:0] offs);
        @(negedge clk);
        stage_sel = sels;
        stage_off = offs;
    endtask

    task automatic mark_fresh();
        @(negedge clk);
        set_fresh = 1'b1;
        @(negedge clk);
        set_fresh = 1'b0;
    endtask

    task automatic pulse_cfg();
        @(negedge clk);
        cfg_pin = 1'b1;
        repeat (3) @(negedge clk);
        cfg_pin = 1'b0;
    endtask

    task automatic model_load();
        for (int k = 0; k < 8; k++) m_sel[k] = stage_sel[k*4 +: 4];
        m_off = stage_off;
    endtask

    initial begin
        for (int k = 0; k < 8; k++) m_sel[k] = 4'd0;
        in_sig = 16'hA5C3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_now("R1 reset state");

        // identity-like layout: output k <- input k
        stage(32'h7654_3210, 8'h00);
        mark_fresh();
        pulse_cfg();
        model_load();
        expect_now("R4 transfer identity");
        check(clr_cnt == 1, "R6 one clear pulse", clr_cnt, 1);
        in_sig = 16'h005A; expect_now("R2 pattern 5A");
        in_sig = 16'hFF81; expect_now("R2 pattern 81");

        // fan-out: every output <- input 5, output 3 off
        stage(32'h5555_5555, 8'h08);
        mark_fresh();
        pulse_cfg();
        model_load();
        in_sig = 16'h0020; expect_now("R2 fan-out high / R3 off output");
        in_sig = 16'hFFDF; expect_now("R2 fan-out low / R3 off output");

        // staged change without transfer, then stale configure
        stage(32'h89AB_CDEF, 8'h00);
        in_sig = 16'h8421; expect_now("R11 staged change ignored");
        pulse_cfg();
        expect_now("R5 stale configure ignored");
        check(clr_cnt == 2, "R6 no clear on stale configure", clr_cnt, 2);

        // reversed layout on upper inputs
        mark_fresh();
        pulse_cfg();
        model_load();
        in_sig = 16'hA700; expect_now("R4 reversed layout A7");
        in_sig = 16'h5900; expect_now("R4 reversed layout 59");
        check(clr_cnt == 3, "R6 clear per transfer", clr_cnt, 3);

        // broadcast and release
        bcast_pin = 1'b1; m_mode = 1;
        in_sig = 16'h5901; expect_now("R8 broadcast one");
        in_sig = 16'hFFFE; expect_now("R8 broadcast zero");
        bcast_pin = 1'b0; m_mode = 0;
        in_sig = 16'hC300; expect_now("R10 broadcast release");

        // shutdown over broadcast, then release
        bcast_pin = 1'b1; shut_pin = 1'b1; m_mode = 2;
        expect_now("R9 shutdown wins");
        bcast_pin = 1'b0;
        expect_now("R7 shutdown held");
        shut_pin = 1'b0; m_mode = 0;
        for (int k = 0; k < 8; k++) m_sel[k] = 4'd0;
        m_off = '1;
        in_sig = 16'hFFFF; expect_now("R7 registers cleared after release");

        // staged bank still reloadable after shutdown
        mark_fresh();
        pulse_cfg();
        model_load();
        in_sig = 16'h3C00; expect_now("R4 reload after shutdown");

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<20000", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule